// File: doc/BRIEF.md
# Core Sampling Policy Controller

This block decides whether a GPU workload gains anything from the shared last-level cache. It does this by running two sampled GPU cores under opposite cache policies. One sampled core always skips the last-level cache. The other always inserts its fills at the most-recently-used position. Every other GPU core is a follower, and this block leaves it unassigned. Both sampled cores report how many instructions they retire in each cycle. The block adds these counts up over a fixed sampling period whose length is a number of cycles.

At the end of each period the block subtracts the bypassing core's total from the MRU-inserting core's total. Because every period has the same length, this comparison of totals is the same as a comparison of throughput, so no divider is needed. The block compares the difference with a programmable threshold. It then registers a cache-friendly flag and its complement, a partition mask bit. The partition mask bit tells the partitioning logic to give the GPU only a minimal share of the cache. A one-cycle pulse marks each new decision. The threshold and the period length are taken from configuration inputs while reset is held.

Top module: `core_sample_ctrl`

## Requirements
- R1: Exactly one core, index BYPASS_CORE (default 0), has the bypass code 2'b01 on `core_policy`. Core i occupies bits [2i+1:2i].
- R2: The core at index MRU_CORE (default 1) has the MRU-insertion code 2'b10 on `core_policy`.
- R3: Every other core has the follower code 2'b00.
- R4: A period is P cycles, counted from the first clock edge after reset is released. `decision_valid` is high for exactly one cycle, right after the P-th edge of each period, and low at all other times.
- R5: The difference is the sum of `mru_retired` over the period minus the sum of `bypass_retired` over the period. The difference may be negative. `cache_friendly` is set to 1 only when the difference is strictly greater than the threshold. Equality or a negative difference gives 0.
- R6: `part_mask` is always the inverse of `cache_friendly`.
- R7: `cache_friendly` and `part_mask` change only in the cycle in which `decision_valid` is high.
- R8: After reset, and before the first decision, `cache_friendly` is 0, `part_mask` is 1 and `decision_valid` is 0.
- R9: `cfg_threshold` and `cfg_period` are captured while `rst_n` is low. Changes to them after reset has been released have no effect on any decision.
- R10: A captured period length of 0 is treated as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while it is low |
| cfg_threshold | input | SUM_W | Threshold on the difference, in instructions per period |
| cfg_period | input | PER_W | Length of the sampling period, in cycles |
| bypass_retired | input | RET_W | Instructions the bypassing sampled core retired this cycle |
| mru_retired | input | RET_W | Instructions the MRU-inserting sampled core retired this cycle |
| core_policy | output | 2*NUM_CORES | Cache policy code for each GPU core |
| cache_friendly | output | 1 | Registered classification from the last period |
| part_mask | output | 1 | Partition mask bit, 1 when the workload is not cache-friendly |
| decision_valid | output | 1 | One-cycle pulse when a new decision is presented |

## Verification
A period counter that drifts shows up at the ports as a `decision_valid` pulse in the wrong cycle. The bench sees that at the very first boundary after reset, because it checks the pulse in every single cycle. An accumulator that misses a cycle's count, or that is not cleared at a boundary, gives a wrong flag in the decision cycle of the affected period or of the period after it. The directed differences of threshold, threshold+1 and a negative value expose this exactly. A wrongly captured threshold or period shows in the first decision after reset, and the bench changes the configuration inputs after reset to catch capture that happens too late.

// File: rtl/csp_pkg.sv
package csp_pkg;
  typedef enum logic [1:0] {
    POL_FOLLOW = 2'b00,
    POL_BYPASS = 2'b01,
    POL_MRU    = 2'b10
  } pol_e;

  // signed difference of the two sampled totals
  function automatic longint sample_delta(input longint mru_sum, input longint byp_sum);
    return mru_sum - byp_sum;
  endfunction

  // strict comparison: equality is not enough to call caching useful
  function automatic logic is_friendly(input longint delta, input longint thr);
    return delta > thr;
  endfunction
endpackage

// File: rtl/csp_policy_map.sv
module csp_policy_map
  import csp_pkg::*;
#(
  parameter int NUM_CORES   = 8,
  parameter int BYPASS_CORE = 0,
  parameter int MRU_CORE    = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [2*NUM_CORES-1:0] policy
);
  logic [NUM_CORES-1:0] byp_sel;
  logic [NUM_CORES-1:0] mru_sel;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    pol_e code;
    assign code = (i == BYPASS_CORE) ? POL_BYPASS :
                  (i == MRU_CORE)    ? POL_MRU    : POL_FOLLOW;
    assign policy[2*i +: 2] = code;
    assign byp_sel[i] = (policy[2*i +: 2] == POL_BYPASS);
    assign mru_sel[i] = (policy[2*i +: 2] == POL_MRU);
  end

  AST_ONE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(byp_sel) == 1); // R1
  AST_ONE_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mru_sel) == 1); // R2
endmodule

// File: rtl/csp_accum.sv
module csp_accum #(
  parameter int RET_W = 4,
  parameter int SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [RET_W-1:0] inc,
  output logic [SUM_W-1:0] total
);
  logic [SUM_W-1:0] acc_q;

  // total includes this cycle's count so the boundary cycle is not lost
  assign total = acc_q + SUM_W'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else          acc_q <= total;
  end

  AST_ACC_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> acc_q >= $past(acc_q)); // R5
endmodule

// File: rtl/csp_decide.sv
module csp_decide
  import csp_pkg::*;
#(
  parameter int SUM_W = 16
) (
  input  logic [SUM_W-1:0] mru_sum,
  input  logic [SUM_W-1:0] byp_sum,
  input  logic [SUM_W-1:0] thr,
  output logic             friendly
);
  longint delta;
  assign delta    = sample_delta(longint'(mru_sum), longint'(byp_sum));
  assign friendly = is_friendly(delta, longint'(thr));
endmodule

// File: rtl/core_sample_ctrl.sv
module core_sample_ctrl #(
  parameter int NUM_CORES   = 8,
  parameter int BYPASS_CORE = 0,
  parameter int MRU_CORE    = 1,
  parameter int RET_W       = 4,
  parameter int PER_W       = 12,
  localparam int SUM_W      = RET_W + PER_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SUM_W-1:0]       cfg_threshold,
  input  logic [PER_W-1:0]       cfg_period,
  input  logic [RET_W-1:0]       bypass_retired,
  input  logic [RET_W-1:0]       mru_retired,
  output logic [2*NUM_CORES-1:0] core_policy,
  output logic                   cache_friendly,
  output logic                   part_mask,
  output logic                   decision_valid
);
  logic [SUM_W-1:0] thr_q;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] cyc_q;
  logic             at_last;
  logic [SUM_W-1:0] mru_total;
  logic [SUM_W-1:0] byp_total;
  logic             verdict;

  // configuration is held in the registers for as long as reset is asserted
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= cfg_threshold;
      per_q <= (cfg_period == '0) ? PER_W'(1) : cfg_period;
    end
  end

  assign at_last = (cyc_q == per_q - PER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)       cyc_q <= '0;
    else if (at_last) cyc_q <= '0;
    else              cyc_q <= cyc_q + PER_W'(1);
  end

  csp_policy_map #(
    .NUM_CORES(NUM_CORES), .BYPASS_CORE(BYPASS_CORE), .MRU_CORE(MRU_CORE)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .policy(core_policy)
  );

  csp_accum #(.RET_W(RET_W), .SUM_W(SUM_W)) u_acc_mru (
    .clk(clk), .rst_n(rst_n), .clr(at_last), .inc(mru_retired), .total(mru_total)
  );

  csp_accum #(.RET_W(RET_W), .SUM_W(SUM_W)) u_acc_byp (
    .clk(clk), .rst_n(rst_n), .clr(at_last), .inc(bypass_retired), .total(byp_total)
  );

  csp_decide #(.SUM_W(SUM_W)) u_dec (
    .mru_sum(mru_total), .byp_sum(byp_total), .thr(thr_q), .friendly(verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cache_friendly <= 1'b0;
      part_mask      <= 1'b1;
      decision_valid <= 1'b0;
    end else begin
      decision_valid <= at_last;
      if (at_last) begin
        cache_friendly <= verdict;
        part_mask      <= ~verdict;
      end
    end
  end

  AST_MASK_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    part_mask != cache_friendly); // R6
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !decision_valid |-> $stable(cache_friendly)); // R7
  AST_PULSE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |-> cyc_q == '0); // R4
  AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    per_q != '0 && cyc_q < per_q); // R10
endmodule

// File: tb/core_sample_ctrl_bench.sv
module core_sample_ctrl_bench;
  localparam int NC = 8;
  localparam int RW = 4;
  localparam int PW = 12;
  localparam int SW = RW + PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] cfg_threshold = '0;
  logic [PW-1:0] cfg_period = PW'(5);
  logic [RW-1:0] bypass_retired = '0;
  logic [RW-1:0] mru_retired = '0;
  logic [2*NC-1:0] core_policy;
  logic cache_friendly, part_mask, decision_valid;

  int checks = 0;
  int errors = 0;
  int cyc_count = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  core_sample_ctrl #(.NUM_CORES(NC), .BYPASS_CORE(0), .MRU_CORE(1),
                     .RET_W(RW), .PER_W(PW)) u_core_sample_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_threshold(cfg_threshold), .cfg_period(cfg_period),
    .bypass_retired(bypass_retired), .mru_retired(mru_retired),
    .core_policy(core_policy), .cache_friendly(cache_friendly),
    .part_mask(part_mask), .decision_valid(decision_valid)
  );

  function automatic bit ref_friendly(input int msum, input int bsum, input int thr);
    int d;
    d = msum - bsum;
    return d > thr;
  endfunction

  function automatic logic [1:0] ref_code(input int idx);
    if (idx == 0) return 2'b01;
    if (idx == 1) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input int thr, input int per);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_threshold = SW'(thr);
    cfg_period = PW'(per);
    bypass_retired = '0;
    mru_retired = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R8 flag", int'(cache_friendly), 0);
    check("R8 mask", int'(part_mask), 1);
    check("R8 valid", int'(decision_valid), 0);
    for (int i = 0; i < NC; i++) begin
      if (i == 0) check("R1 bypass code", int'(core_policy[2*i +: 2]), int'(ref_code(i)));
      else if (i == 1) check("R2 mru code", int'(core_policy[2*i +: 2]), int'(ref_code(i)));
      else check("R3 follower code", int'(core_policy[2*i +: 2]), int'(ref_code(i)));
    end
  endtask

  // mode 0: constant a/b per cycle; mode 1: random per cycle
  task automatic run_period(input int p, input int thr, input int mode, input int a, input int b);
    int ms = 0;
    int bs = 0;
    bit prev;
    bit exp;
    prev = cache_friendly;
    for (int c = 0; c < p; c++) begin
      if (mode == 1) begin
        mru_retired = RW'($urandom_range(15, 0));
        bypass_retired = RW'($urandom_range(15, 0));
      end else begin
        mru_retired = RW'(a);
        bypass_retired = RW'(b);
      end
      ms += int'(mru_retired);
      bs += int'(bypass_retired);
      @(posedge clk);
      @(negedge clk);
      if (c < p - 1) begin
        check("R4 no pulse mid-period", int'(decision_valid), 0);
        check("R7 flag held", int'(cache_friendly), int'(prev));
      end
    end
    exp = ref_friendly(ms, bs, thr);
    check("R4 pulse at boundary", int'(decision_valid), 1);
    check("R5 flag", int'(cache_friendly), int'(exp));
    check("R6 mask", int'(part_mask), int'(!exp));
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    // equality is not friendly: diff 20, thr 20
    do_reset(20, 5);
    run_period(5, 20, 0, 6, 2);
    // R9: threshold and period changed after reset must be ignored
    cfg_threshold = '0;
    cfg_period = PW'(9);
    run_period(5, 20, 0, 3, 2);
    // just above threshold
    do_reset(19, 5);
    run_period(5, 19, 0, 6, 2);
    // negative difference, then small positive
    do_reset(0, 5);
    run_period(5, 0, 0, 1, 9);
    run_period(5, 0, 0, 2, 1);
    run_period(5, 0, 0, 0, 0);
    // R10: zero period acts as one cycle
    do_reset(3, 0);
    run_period(1, 3, 0, 5, 1);
    run_period(1, 3, 0, 4, 1);
    run_period(1, 3, 0, 9, 2);
    // random stimulus
    for (int r = 0; r < 3; r++) begin
      int t;
      int p;
      t = $urandom_range(12, 0);
      p = $urandom_range(9, 2);
      do_reset(t, p);
      for (int k = 0; k < 15; k++) run_period(p, t, 1, 0, 0);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc_count++;
      if (cyc_count > 100000 && !done) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc_count);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end
endmodule